// File: doc/BRIEF.md
# Job ring queue controller

This block moves work between software and an execution engine through two rings in memory. Software writes descriptor addresses into an input ring and then reports how many it added. The controller fetches each address, passes it to an execution stub, and writes a two-word completion record (the descriptor address, then a status word) into an output ring. Software reads how many completion records are waiting and reports how many it has consumed. The stub takes `EXEC_CYCLES` cycles and returns the value held in a programmable status register.

Completions raise a done flag. The flag is coalesced by a completion-count threshold and by an idle timeout, and a mask keeps it off the `irq` pin. A command bit drives a two-step shutdown. The first write stops the ring and discards queued jobs. The second write, made once the halt has completed, performs a timed reset that clears indices and counts and then clears itself.

Registers sit on a single-cycle write bus with a combinational read port. Memory is reached through a request/acknowledge port that carries one access at a time.

Top module: `jrq_ctrl`

## Requirements
- R1: The word-addressed registers are laid out as follows.
  - 0: input base
  - 1: input size
  - 2: output base
  - 3: output size
  - 4: input free (read-only)
  - 5: job add (write-only)
  - 6: output used (read-only)
  - 7: output remove (write-only)
  - 8: interrupt status
  - 9: interrupt configuration
  - 10: command
  - 11: stub status

  Input slot i is read from input base + 4·i. Output slot j is written at output base + 8·j (descriptor address) and output base + 8·j + 4 (status). Indices wrap at the programmed size, and a size of 1 works.
- R2: Input free reads input size minus the jobs queued and not yet fetched. It reads zero when the ring is full.
- R3: Writing N to job add queues N jobs. They are processed in ring order, and each completion record holds the fetched descriptor address and the stub status value.
- R4: Output used rises by one per completion. Writing N to output remove lowers it by N, but never below zero. A completion and a remove in the same cycle are netted, with the completion counted first.
- R5: No job is started while output used equals output size. Processing resumes once software removes an entry.
- R6: The first write of command bit 0 stops new jobs, discards queued jobs and sets interrupt status bits [3:2] to 1 (halt in progress) while a job is in flight. Those bits become 2 (halt complete) once the job has posted, or at once if the engine was idle. Job add writes are ignored while halted.
- R7: A second write of command bit 0 after halt complete sets command bit 0 for `RST_CYCLES` cycles. When the bit clears, ring indices, counts, the done flag and the halt state are all back to zero. A command write while the halt is in progress is ignored.
- R8: Interrupt configuration bits [15:8] hold the count threshold (0 is treated as 1). The done flag (interrupt status bit 0) sets on the completion that brings the count of completions since the last flag-setting event to the threshold.
- R9: Interrupt configuration bits [31:16] hold a timeout T. If T is non-zero and below-threshold completions are pending, the done flag sets T cycles after the latest completion, provided no further completion arrives in that window.
- R10: Interrupt configuration bit 0 masks the `irq` output while the done flag still sets. Writing 1 to interrupt status bit 0 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted; read data valid |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Done interrupt, gated by the mask |

## Verification
A completion and a software remove can land on the same clock edge. With the output ring empty, the net result shows whether the completion was counted before the saturating decrement. The bench counts the fixed fetch, execute and write latency from a job-add write, lands the remove write on exactly the completion edge, and expects output used to read 0 rather than 1. A flush request can also arrive while a job is mid-flight. The bench issues it two cycles after a job add and expects the halt-in-progress code, followed by one posted record and no further work.

// File: rtl/jrq_ctrl.sv
module jrq_ctrl #(
  parameter int AW          = 32,
  parameter int MAX_RING    = 16,
  parameter int EXEC_CYCLES = 3,
  parameter int RST_CYCLES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int CW = $clog2(MAX_RING + 1);
  localparam int EW = $clog2(EXEC_CYCLES + 1);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [EW-1:0] EXEC_LAST = EW'(EXEC_CYCLES - 1);
  localparam logic [RW-1:0] RST_LAST  = RW'(RST_CYCLES - 1);
  localparam logic [1:0] H_NONE = 2'd0, H_PROG = 2'd1, H_DONE = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_WADDR, S_WSTAT} st_t;

  logic [AW-1:0] in_base, out_base;
  logic [CW-1:0] in_size, out_size;
  logic          mask;
  logic [7:0]    thr;
  logic [15:0]   tout;
  logic [31:0]   job_stat;

  st_t           st;
  logic [CW-1:0] in_rd, out_wr, pending, out_used;
  logic [31:0]   desc, stat_lat;
  logic [EW-1:0] ecnt;
  logic [1:0]    halt;
  logic          rst_busy;
  logic [RW-1:0] rcnt;
  logic          done_bit, armed;
  logic [7:0]    cnt;
  logic [15:0]   tmr;

  wire [CW-1:0] wr_n      = reg_wdata[CW-1:0];
  wire          idle      = (st == S_IDLE);
  wire          cmd_wr    = reg_wr && reg_addr == 4'd10 && reg_wdata[0] && !rst_busy;
  wire          flush_go  = cmd_wr && halt == H_NONE;
  wire          rst_go    = cmd_wr && halt == H_DONE;
  wire          rst_done  = rst_busy && rcnt == RST_LAST;
  wire          wr_add    = reg_wr && reg_addr == 4'd5 && halt == H_NONE && !rst_busy;
  wire          wr_rmv    = reg_wr && reg_addr == 4'd7;
  wire          w1c       = reg_wr && reg_addr == 4'd8 && reg_wdata[0];
  wire          start     = idle && halt == H_NONE && !rst_busy && !flush_go &&
                            pending != '0 && out_used < out_size;
  wire          done_evt  = (st == S_WSTAT) && mem_ack;
  wire [7:0]    thr_eff   = (thr == 8'd0) ? 8'd1 : thr;
  wire          hit_cnt   = done_evt && ({1'b0, cnt} + 9'd1 >= {1'b0, thr_eff});
  wire          hit_tmr   = armed && !done_evt && tmr == tout;

  logic [CW:0] used_inc, used_nxt;
  always_comb begin
    used_inc = {1'b0, out_used} + {{CW{1'b0}}, done_evt};
    used_nxt = used_inc;
    if (wr_rmv) used_nxt = (used_inc > {1'b0, wr_n}) ? used_inc - {1'b0, wr_n} : '0;
  end

  assign mem_req   = (st == S_FETCH) || (st == S_WADDR) || (st == S_WSTAT);
  assign mem_we    = (st == S_WADDR) || (st == S_WSTAT);
  assign mem_addr  = (st == S_FETCH) ? in_base + AW'({in_rd, 2'b00})
                   : out_base + AW'({out_wr, 3'b000}) + ((st == S_WSTAT) ? AW'(4) : AW'(0));
  assign mem_wdata = (st == S_WSTAT) ? stat_lat : desc;
  assign irq       = done_bit && !mask;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0:  reg_rdata = 32'(in_base);
      4'd1:  reg_rdata = 32'(in_size);
      4'd2:  reg_rdata = 32'(out_base);
      4'd3:  reg_rdata = 32'(out_size);
      4'd4:  reg_rdata = 32'(in_size - pending);
      4'd6:  reg_rdata = 32'(out_used);
      4'd8:  reg_rdata = {28'd0, halt, 1'b0, done_bit};
      4'd9:  reg_rdata = {tout, thr, 7'd0, mask};
      4'd10: reg_rdata = {31'd0, rst_busy};
      4'd11: reg_rdata = job_stat;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_base <= '0; out_base <= '0; in_size <= CW'(1); out_size <= CW'(1);
      mask <= 1'b0; thr <= 8'd1; tout <= '0; job_stat <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        4'd0:  in_base  <= reg_wdata[AW-1:0];
        4'd1:  in_size  <= wr_n;
        4'd2:  out_base <= reg_wdata[AW-1:0];
        4'd3:  out_size <= wr_n;
        4'd9:  begin mask <= reg_wdata[0]; thr <= reg_wdata[15:8]; tout <= reg_wdata[31:16]; end
        4'd11: job_stat <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; in_rd <= '0; out_wr <= '0; pending <= '0; out_used <= '0;
      desc <= '0; stat_lat <= '0; ecnt <= '0;
    end else if (rst_done) begin
      in_rd <= '0; out_wr <= '0; pending <= '0; out_used <= '0;
    end else begin
      if (flush_go) pending <= '0;
      else          pending <= pending + (wr_add ? wr_n : '0) - (start ? CW'(1) : '0);
      out_used <= used_nxt[CW-1:0];
      case (st)
        S_IDLE:  if (start) st <= S_FETCH;
        S_FETCH: if (mem_ack) begin
          desc  <= mem_rdata;
          in_rd <= (in_rd + CW'(1) >= in_size) ? '0 : in_rd + CW'(1);
          ecnt  <= '0;
          st    <= S_EXEC;
        end
        S_EXEC: begin
          ecnt <= ecnt + EW'(1);
          if (ecnt == EXEC_LAST) begin stat_lat <= job_stat; st <= S_WADDR; end
        end
        S_WADDR: if (mem_ack) st <= S_WSTAT;
        S_WSTAT: if (mem_ack) begin
          out_wr <= (out_wr + CW'(1) >= out_size) ? '0 : out_wr + CW'(1);
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= H_NONE; rst_busy <= 1'b0; rcnt <= '0;
    end else begin
      if (rst_done)                     halt <= H_NONE;
      else if (flush_go)                halt <= idle ? H_DONE : H_PROG;
      else if (halt == H_PROG && idle)  halt <= H_DONE;
      if (rst_go) begin
        rst_busy <= 1'b1; rcnt <= '0;
      end else if (rst_busy) begin
        if (rst_done) rst_busy <= 1'b0;
        else          rcnt <= rcnt + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_bit <= 1'b0; cnt <= '0; tmr <= '0; armed <= 1'b0;
    end else if (rst_done) begin
      done_bit <= 1'b0; cnt <= '0; armed <= 1'b0;
    end else begin
      if (hit_cnt || hit_tmr) done_bit <= 1'b1;
      else if (w1c)           done_bit <= 1'b0;
      if (done_evt) begin
        cnt   <= hit_cnt ? 8'd0 : cnt + 8'd1;
        armed <= !hit_cnt && tout != 16'd0;
        tmr   <= 16'd1;
      end else if (hit_tmr) begin
        cnt   <= 8'd0;
        armed <= 1'b0;
      end else if (armed) begin
        tmr <= tmr + 16'd1;
      end
    end
  end

  p_done_has_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WSTAT && mem_ack) |-> out_used < out_size);
  p_no_start_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && out_used >= out_size) |=> st == S_IDLE);
  p_halt_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt != H_NONE && st == S_IDLE) |=> st == S_IDLE);
  p_reset_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> (pending == '0 && out_used == '0 && halt == H_NONE && !done_bit));
  p_single_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WSTAT && mem_ack && thr <= 8'd1) |=> done_bit);
endmodule

// File: tb/jrq_ctrl_test.sv
module jrq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic irq;
  logic [31:0] mem [0:255];
  int checks = 0;
  int errors = 0;
  int cur_s = 1;

  always #5 clk = ~clk;

  jrq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] dsc(input int s, input int j);
    return 32'hD000_0000 | 32'(s << 8) | 32'(j);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rnow(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rnow(a, d);
  endtask

  task automatic wait_reg(input logic [3:0] a, input logic [31:0] m, input logic [31:0] e, input string tag);
    logic [31:0] d;
    for (int i = 0; i < 300; i++) begin
      rreg(a, d);
      if ((d & m) == e) break;
    end
    chk(tag, d & m, e);
  endtask

  task automatic reset_seq();
    wreg(4'd10, 32'd1);
    wait_reg(4'd8, 32'hC, 32'h8, "R6 halt complete before reset");
    wreg(4'd10, 32'd1);
    wait_reg(4'd10, 32'h1, 32'h0, "R7 reset bit self-clears");
  endtask

  task automatic cfg(input int s);
    cur_s = s;
    wreg(4'd0, 32'h100); wreg(4'd1, 32'(s));
    wreg(4'd2, 32'h200); wreg(4'd3, 32'(s));
    wreg(4'd9, 32'h100);
    for (int j = 0; j < 8; j++) mem[64 + j] = dsc(s, j);
  endtask

  task automatic clear_out();
    @(negedge clk);
    for (int j = 0; j < 16; j++) mem[128 + j] = 32'h0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c;
    for (int j = 0; j < 256; j++) mem[j] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rnow(4'd4, d);  chk("R2 reset free", d, 32'd1);
    rnow(4'd6, d);  chk("R4 reset used", d, 32'd0);
    rnow(4'd8, d);  chk("R10 reset status", d, 32'd0);
    rnow(4'd10, d); chk("R7 reset cmd", d, 32'd0);
    chk("R10 reset irq", {31'd0, irq}, 32'd0);

    for (int s = 1; s <= 4; s++) begin
      for (int n = 1; n <= s; n++) begin
        reset_seq();
        cfg(s);
        clear_out();
        wreg(4'd11, 32'h5A00 + 32'(s * 16 + n));
        wreg(4'd5, 32'(n));
        rnow(4'd4, d); chk("R2 free after add", d, 32'(s - n));
        wait_reg(4'd6, 32'hFFFF_FFFF, 32'(n), "R3 used after jobs");
        for (int k = 0; k < n; k++) begin
          chk("R3 record address", mem[128 + 2 * k], dsc(s, k));
          chk("R3 record status", mem[129 + 2 * k], 32'h5A00 + 32'(s * 16 + n));
        end
        rreg(4'd4, d); chk("R2 free drained", d, 32'(s));
        wreg(4'd7, 32'(n));
        rnow(4'd6, d); chk("R4 used after remove", d, 32'd0);
        clear_out();
        wreg(4'd5, 32'(s));
        wait_reg(4'd6, 32'hFFFF_FFFF, 32'(s), "R1 wrap fill");
        for (int j = 0; j < s; j++)
          chk("R1 wrapped record", mem[128 + 2 * j], dsc(s, j));
        wreg(4'd5, 32'd1);
        repeat (20) @(negedge clk);
        rnow(4'd6, d); chk("R5 held while full", d, 32'(s));
        rnow(4'd4, d); chk("R2 free with one queued", d, 32'(s - 1));
        wreg(4'd7, 32'd1);
        wait_reg(4'd6, 32'hFFFF_FFFF, 32'(s), "R5 resumes after remove");
        wreg(4'd7, 32'(s));
        rnow(4'd6, d); chk("R4 remove all", d, 32'd0);
        wreg(4'd7, 32'd3);
        rnow(4'd6, d); chk("R4 floor at zero", d, 32'd0);
      end
    end

    reset_seq();
    cfg(4);
    wreg(4'd5, 32'd3);
    wreg(4'd10, 32'd1);
    wreg(4'd10, 32'd1);
    rnow(4'd8, d); chk("R6 halt in progress", d & 32'hC, 32'h4);
    wait_reg(4'd8, 32'hC, 32'h8, "R6 halt completes");
    rnow(4'd10, d); chk("R7 write during halt ignored", d, 32'd0);
    rnow(4'd6, d);  chk("R6 in-flight job posted only", d, 32'd1);
    rnow(4'd4, d);  chk("R6 queue discarded", d, 32'd4);
    wreg(4'd5, 32'd2);
    rnow(4'd4, d);  chk("R6 add ignored while halted", d, 32'd4);
    repeat (10) @(negedge clk);
    rnow(4'd6, d);  chk("R6 no work while halted", d, 32'd1);
    wreg(4'd10, 32'd1);
    c = 0;
    rnow(4'd10, d);
    while (d[0] && c < 50) begin c++; rreg(4'd10, d); end
    chk("R7 reset duration", 32'(c), 32'd4);
    rnow(4'd8, d);  chk("R7 halt cleared", d, 32'd0);
    rnow(4'd6, d);  chk("R7 used cleared", d, 32'd0);
    rnow(4'd4, d);  chk("R7 free restored", d, 32'd4);
    clear_out();
    wreg(4'd5, 32'd1);
    wait_reg(4'd6, 32'hFFFF_FFFF, 32'd1, "R7 job after reset");
    chk("R7 indices restart at slot 0", mem[128], dsc(4, 0));

    reset_seq();
    cfg(4);
    wreg(4'd5, 32'd1);
    repeat (6) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 32'd1;
    @(negedge clk); reg_wr = 1'b0;
    rnow(4'd6, d); chk("R4 completion and remove same edge", d, 32'd0);
    chk("R4 record written", mem[128], dsc(4, 0));

    wreg(4'd8, 32'd1);
    wreg(4'd9, 32'h0300);
    wreg(4'd5, 32'd2);
    wait_reg(4'd6, 32'hFFFF_FFFF, 32'd2, "R8 two done");
    repeat (5) @(negedge clk);
    rnow(4'd8, d); chk("R8 below threshold", d & 32'h1, 32'h0);
    chk("R8 irq low below threshold", {31'd0, irq}, 32'd0);
    wreg(4'd5, 32'd1);
    wait_reg(4'd6, 32'hFFFF_FFFF, 32'd3, "R8 third done");
    rreg(4'd8, d); chk("R8 threshold reached", d & 32'h1, 32'h1);
    chk("R8 irq high", {31'd0, irq}, 32'd1);
    wreg(4'd8, 32'd1);
    rnow(4'd8, d); chk("R10 write-one clears", d & 32'h1, 32'h0);

    wreg(4'd7, 32'd3);
    wreg(4'd9, 32'h000A_0800);
    wreg(4'd5, 32'd1);
    wait_reg(4'd6, 32'hFFFF_FFFF, 32'd1, "R9 one done");
    c = 0;
    rnow(4'd8, d);
    while (!d[0] && c < 50) begin c++; rreg(4'd8, d); end
    chk("R9 timeout cycles", 32'(c), 32'd10);

    wreg(4'd8, 32'd1);
    wreg(4'd7, 32'd1);
    wreg(4'd9, 32'h0101);
    wreg(4'd5, 32'd1);
    wait_reg(4'd6, 32'hFFFF_FFFF, 32'd1, "R10 one done");
    rreg(4'd8, d); chk("R10 flag sets while masked", d & 32'h1, 32'h1);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    wreg(4'd9, 32'h0100);
    chk("R10 irq after unmask", {31'd0, irq}, 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule